// File: doc/BRIEF.md
# Stepped power-down output clock divider

This block divides a fast clock down to an output clock. A 2-bit select picks one of four ratios, and the output stays at 50% duty cycle for each of them. The block runs on `clk_fast`, a clock at twice the VCO frequency, and counts in half VCO periods. Divide-by-1 therefore gives a square wave at the VCO frequency, with high and low phases of equal length.

A power-down request does not stop the clock. It moves a step level that adds an extra divide factor of 2, 4, 8 and then 16 on top of the selected ratio. The level moves by one step on each rising edge of a slow reference clock. Both the request and the reference clock are synchronized into the fast domain before use.

When the request is released, the level walks back down one step per reference edge. The output returns to its programmed frequency in four discrete increments. Any change of ratio, whether from the select or from a step, is applied only when the output rises, so no shortened pulse appears.

Top module: `outdiv_stepped`

## Requirements
- R1: With the step level at zero, each output half-period lasts 2^n cycles of `clk_fast`, where n is `n_sel`: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8.
- R2: Every low phase of `clk_out` is as long as the high phase just before it (50% duty cycle).
- R3: While `pd_req` is held, the output half-period settles at 16 times its programmed value.
- R4: The step level changes by one on each synchronized rising edge of `ref_clk` and at no other time. From full rate, reaching the divide-by-16 factor takes four reference edges.
- R5: After `pd_req` is released, the high-phase width passes through exactly the sequence 16, 8, 4, 2, 1 times the programmed half-period.
- R6: A ratio change takes effect only at a rising edge of `clk_out`, so every high phase has a power-of-two width in `clk_fast` cycles.
- R7: `pd_req` and `ref_clk` pass through a two-stage synchronizer. The output follows a cycle-exact behaviour that includes this latency.
- R8: `full_rate` is high exactly when the extra divide factor applied to the output is 1.
- R9: During reset `clk_out` is low and `full_rate` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock at twice the VCO frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock that paces the step sequence |
| pd_req | input | 1 | Power-down request, asynchronous |
| n_sel | input | 2 | Programmed ratio select |
| clk_out | output | 1 | Divided output clock |
| full_rate | output | 1 | High when no extra divide factor is applied |

## Verification
The bench builds the block with its defaults: a 2-bit select, four power-down steps and two synchronizer stages. The largest combined half-period is then 128 cycles, which exercises the full counter width when `n_sel` is 11 under power-down. The reference clock period is 600 fast cycles, far longer than the slowest stepped output period at divide-by-1. Each of the four release increments therefore shows up as several whole output periods, and the climb sequence can be read directly from the high-phase widths.

// File: rtl/outdiv_stepped.sv
module outdiv_stepped #(
  parameter int NW    = 2,
  parameter int STEPS = 4,
  parameter int SYNC  = 2
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          pd_req,
  input  logic [NW-1:0] n_sel,
  output logic          clk_out,
  output logic          full_rate
);
  localparam int NMAX = (2 ** NW) - 1;
  localparam int EMAX = NMAX + STEPS;
  localparam int CW   = EMAX;
  localparam int EW   = $clog2(EMAX + 1);
  localparam int LW   = $clog2(STEPS + 1);

  logic [SYNC-1:0] pd_sy;
  logic [SYNC:0]   rf_sy;
  logic [LW-1:0]   lvl, l_act;
  logic [NW-1:0]   n_act;
  logic [CW-1:0]   cnt;
  logic            out_q;
  logic [EW-1:0]   e_act;
  logic [CW:0]     half;
  logic            tick, pd_s, wrap;

  assign tick  = rf_sy[SYNC-1] & ~rf_sy[SYNC];
  assign pd_s  = pd_sy[SYNC-1];
  assign e_act = EW'(n_act) + EW'(l_act);
  assign half  = (CW+1)'(1) << e_act;
  assign wrap  = ({1'b0, cnt} == half - (CW+1)'(1));

  assign clk_out   = out_q;
  assign full_rate = (l_act == '0);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      pd_sy <= '0;
      rf_sy <= '0;
    end else begin
      pd_sy <= {pd_sy[SYNC-2:0], pd_req};
      rf_sy <= {rf_sy[SYNC-1:0], ref_clk};
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0;
    end else if (tick) begin
      if (pd_s && lvl != LW'(STEPS)) lvl <= lvl + 1'b1;
      else if (!pd_s && lvl != '0)   lvl <= lvl - 1'b1;
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b0;
      n_act <= '0;
      l_act <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      out_q <= ~out_q;
      if (!out_q) begin
        n_act <= n_sel;
        l_act <= lvl;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_fast) disable iff (!rst_n)
    {1'b0, cnt} < half); // R1
  AST_HALVES_MATCH: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $fell(out_q) |-> ($stable(n_act) && $stable(l_act))); // R2
  AST_LVL_MAX: assert property (@(posedge clk_fast) disable iff (!rst_n)
    lvl <= LW'(STEPS)); // R3
  AST_LVL_ON_TICK: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> $past(tick)); // R4
  AST_RATIO_AT_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ((n_act != $past(n_act)) || (l_act != $past(l_act))) |-> $rose(out_q)); // R6
  AST_FULL_AT_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(full_rate) |-> $rose(out_q)); // R8
endmodule

// File: tb/outdiv_stepped_bench.sv
module outdiv_stepped_bench;
  localparam int REF_HALF = 300;

  logic clk_fast = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic pd_req = 1'b0;
  logic [1:0] n_sel = 2'b00;
  logic clk_out, full_rate;

  int n_checks = 0, n_fail = 0;
  int cycle = 0;

  outdiv_stepped u_outdiv_stepped (
    .clk_fast(clk_fast), .rst_n(rst_n), .ref_clk(ref_clk), .pd_req(pd_req),
    .n_sel(n_sel), .clk_out(clk_out), .full_rate(full_rate)
  );

  always #2 clk_fast = ~clk_fast;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  initial begin
    forever begin
      repeat (REF_HALF) @(negedge clk_fast);
      ref_clk = ~ref_clk;
    end
  end

  // behavioural reference, advanced on every rising edge
  int m_pd1, m_pd2, m_r1, m_r2, m_r3, m_lvl, m_nact, m_lact, m_cnt, m_out;
  always @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      m_pd1 = 0; m_pd2 = 0; m_r1 = 0; m_r2 = 0; m_r3 = 0;
      m_lvl = 0; m_nact = 0; m_lact = 0; m_cnt = 0; m_out = 0;
    end else begin
      int step_now, pd_now, lvl_old, half;
      step_now = (m_r2 == 1 && m_r3 == 0) ? 1 : 0;
      pd_now = m_pd2;
      lvl_old = m_lvl;
      m_pd2 = m_pd1; m_pd1 = pd_req;
      m_r3 = m_r2; m_r2 = m_r1; m_r1 = ref_clk;
      if (step_now == 1) begin
        if (pd_now == 1 && m_lvl < 4) m_lvl++;
        else if (pd_now == 0 && m_lvl > 0) m_lvl--;
      end
      half = 1 << (m_nact + m_lact);
      if (m_cnt == half - 1) begin
        m_cnt = 0;
        if (m_out == 0) begin
          m_nact = n_sel;
          m_lact = lvl_old;
        end
        m_out = 1 - m_out;
      end else m_cnt++;
    end
  end

  // phase width monitor
  int seg = 0, prev = 0, last_high = 0, last_low = 0;
  bit have_high = 0;
  bit rec_on = 0;
  int climb[$];
  always @(negedge clk_fast) begin
    cycle++;
    if (!rst_n) begin
      check(clk_out == 1'b0, "R9 clk_out in reset", clk_out, 0);
      check(full_rate == 1'b1, "R9 full_rate in reset", full_rate, 1);
      seg = 0; prev = 0; have_high = 0;
    end else begin
      check(clk_out == m_out[0], "R7 clk_out vs reference", clk_out, m_out);
      check(full_rate == (m_lact == 0), "R8 full_rate vs reference", full_rate, (m_lact == 0));
      if (clk_out == prev[0]) seg++;
      else begin
        if (prev == 1) begin
          last_high = seg;
          have_high = 1;
          check((seg & (seg - 1)) == 0, "R6 high width power of two", seg, 0);
          if (rec_on && (climb.size() == 0 || climb[$] != seg)) climb.push_back(seg);
        end else if (have_high) begin
          last_low = seg;
          check(seg == last_high, "R2 low equals preceding high", seg, last_high);
        end
        seg = 1;
      end
      prev = clk_out;
    end
  end

  initial begin
    #(4 * 200000);
    check(0, "watchdog", cycle, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int t0, t1;
    repeat (5) @(negedge clk_fast);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) begin
      n_sel = 2'(n);
      repeat (1200) @(negedge clk_fast);
      check(last_high == (1 << n), "R1 high width for n_sel", last_high, 1 << n);
      check(last_low == (1 << n), "R2 low width for n_sel", last_low, 1 << n);
      check(full_rate == 1'b1, "R8 full rate without power-down", full_rate, 1);
    end
    pd_req = 1'b1;
    repeat (3600) @(negedge clk_fast);
    check(last_high == 128, "R3 n_sel=11 under power-down", last_high, 128);
    check(full_rate == 1'b0, "R8 full_rate low under power-down", full_rate, 0);
    pd_req = 1'b0;
    n_sel = 2'b00;
    repeat (3600) @(negedge clk_fast);
    check(last_high == 1, "R1 back to divide-by-1", last_high, 1);
    pd_req = 1'b1;
    t0 = cycle;
    while (last_high != 16 && cycle - t0 < 6000) @(negedge clk_fast);
    t1 = cycle - t0;
    check(t1 >= 1800 && t1 <= 2700, "R4 four reference steps to reach x16", t1, 2400);
    repeat (600) @(negedge clk_fast);
    check(last_high == 16, "R3 n_sel=00 under power-down", last_high, 16);
    climb.delete();
    rec_on = 1;
    pd_req = 1'b0;
    repeat (3600) @(negedge clk_fast);
    rec_on = 0;
    check(climb.size() == 5, "R5 number of climb widths", climb.size(), 5);
    for (int i = 0; i < 5; i++) begin
      int got;
      got = (i < climb.size()) ? climb[i] : -1;
      check(got == (16 >> i), "R5 climb width", got, 16 >> i);
    end
    check(full_rate == 1'b1, "R8 full_rate after climb", full_rate, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_fast);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule